// File: doc/BRIEF.md
# Cascadable Presettable Modulo-16 Counter

This block is a 4-bit synchronous up-counter that steps from 0 to 15 and then rolls over to 0. A low level on the load input presets the counter from a 4-bit data bus. Two count enables must both be high for the counter to advance. A terminal-count output lets several counters be chained into one wider counter.

The parallel enable gates counting only. The trickle enable gates both counting and terminal count. To build a wider counter, connect each stage's terminal count to the next stage's trickle enable and drive every parallel enable from one shared signal. A build-time parameter selects how the active-low clear works: asynchronously (immediate, ignores the clock) or synchronously (applied at the rising edge).

Top module: `mod16_cascade_counter`

## Requirements
- R1: Each counting edge adds one to the count, and a count of 15 becomes 0 on the next counting edge.
- R2: With ASYNC_CLEAR=0, a low clr_n at a rising edge sets count to 0, even when load_n is low and both enables are high. The count does not change before that edge.
- R3: With ASYNC_CLEAR=1, a low clr_n sets count to 0 at once, without waiting for a clock edge.
- R4: When clr_n is high and load_n is low, a rising edge copies din into count, whatever the enable levels.
- R5: When clr_n and load_n are both high, a rising edge increments count only if en_par and en_trk are both 1.
- R6: When clr_n and load_n are both high and either enable is 0, count keeps its value across the edge.
- R7: tc is 1 exactly when count is 15 and en_trk is 1. The level of en_par has no effect on tc.
- R8: Three stages chained through tc into en_trk, sharing en_par, count as one 12-bit counter (stage 0 is the least significant) and wrap from 4095 to 0.
- R9: Changes on din, load_n or the enables between clock edges leave count unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous depending on ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous preset from din |
| en_par | input | 1 | Count enable shared by all stages of a chain |
| en_trk | input | 1 | Count enable that also gates tc; takes the previous stage's tc |
| din | input | W | Preset value |
| count | output | W | Current count |
| tc | output | 1 | Terminal count: all ones and en_trk high |

## Verification
The bench checks the following corner cases, each against the failure it would expose:
- **Rollover from 15 to 0.** Both a preset to 15 and natural counting reach 15 before the rollover. A design with a wrong modulus would show 16 or stick at 15.
- **Asynchronous clear mid-cycle.** A clear dropped in the middle of a cycle must reach zero at once. A design that samples it on the clock would still show the old count.
- **Synchronous clear against load and both enables.** The clear must win. A design with the wrong priority would load or count instead.
- **Terminal count gating.** Toggling en_par at count 15 shows whether tc wrongly follows it.
- **Three-stage chain across 4095.** A design whose terminal count ignores the trickle enable would make the upper stages run early and break the 12-bit sequence.

// File: rtl/mod16_cascade_counter.sv
`timescale 1ns/1ps
module mod16_cascade_counter #(
  parameter bit ASYNC_CLEAR = 1'b1,
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_par,
  input  logic         en_trk,
  input  logic [W-1:0] din,
  output logic [W-1:0] count,
  output logic         tc
);
  localparam logic [W-1:0] TOP = '1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] nxt;

  always_comb begin
    if (!load_n)               nxt = din;
    else if (en_par && en_trk) nxt = count + ONE;
    else                       nxt = count;
  end

  generate
    if (ASYNC_CLEAR) begin : g_async
      always_ff @(posedge clk or negedge clr_n)
        if (!clr_n) count <= '0;
        else        count <= nxt;
    end else begin : g_sync
      always_ff @(posedge clk)
        count <= clr_n ? nxt : '0;
    end
  endgenerate

  assign tc = en_trk && (count == TOP);

  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(din));

  p_step_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && en_trk) |=> count == $past(count) + ONE);

  p_hold_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_par && en_trk)) |=> $stable(count));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_par && tc) |=> count == '0);
endmodule

// File: tb/sim_mod16_cascade_counter.sv
`timescale 1ns/1ps
module sim_mod16_cascade_counter;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0, bad = 0;

  // shared stimulus for an asynchronous-clear unit (u0) and a synchronous-clear unit (u1)
  logic       clr_a_n = 1'b0, clr_s_n = 1'b0, load_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] qa, qs;
  logic       tca, tcs;

  mod16_cascade_counter #(.ASYNC_CLEAR(1'b1), .W(4)) u0 (
    .clk(clk), .clr_n(clr_a_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
    .din(din), .count(qa), .tc(tca));
  mod16_cascade_counter #(.ASYNC_CLEAR(1'b0), .W(4)) u1 (
    .clk(clk), .clr_n(clr_s_n), .load_n(load_n), .en_par(en_par), .en_trk(en_trk),
    .din(din), .count(qs), .tc(tcs));

  // three-stage chain
  logic       c_clr_n = 1'b0, c_en = 1'b0;
  logic [3:0] cq [3];
  logic       ctc [3];
  for (genvar g = 0; g < 3; g++) begin : g_chain
    logic trk;
    if (g == 0) begin : g_first
      assign trk = 1'b1;
    end else begin : g_rest
      assign trk = ctc[g-1];
    end
    mod16_cascade_counter #(.ASYNC_CLEAR(1'b1), .W(4)) u_st (
      .clk(clk), .clr_n(c_clr_n), .load_n(1'b1), .en_par(c_en), .en_trk(trk),
      .din(4'd0), .count(cq[g]), .tc(ctc[g]));
  end
  wire [11:0] chain_val = {cq[2], cq[1], cq[0]};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    tick();
    check("R3 reset u0", qa, 0);
    check("R2 reset u1", qs, 0);
    clr_a_n = 1'b1; clr_s_n = 1'b1;
  endtask

  task automatic t_count_hold();
    en_par = 1'b1; en_trk = 1'b1;
    tick(); tick(); tick();
    check("R5 count u0", qa, 3);
    check("R5 count u1", qs, 3);
    en_par = 1'b0; tick();
    check("R6 hold par low", qa, 3);
    en_par = 1'b1; en_trk = 1'b0; tick();
    check("R6 hold trk low", qs, 3);
    en_trk = 1'b1;
  endtask

  task automatic t_load_wrap();
    en_par = 1'b0; en_trk = 1'b0; load_n = 1'b0; din = 4'd15; tick();
    check("R4 load with enables low", qa, 15);
    load_n = 1'b1; en_trk = 1'b1;
    #1 check("R7 tc with par low", tca, 1);
    en_trk = 1'b0;
    #1 check("R7 tc trk low", tca, 0);
    en_par = 1'b1; en_trk = 1'b1; tick();
    check("R1 wrap u0", qa, 0);
    check("R1 wrap u1", qs, 0);
    check("R7 tc after wrap", tca, 0);
    load_n = 1'b0; din = 4'd9; tick();
    check("R4 load with enables high", qs, 9);
    load_n = 1'b1;
  endtask

  task automatic t_midcycle();
    en_par = 1'b0;
    #1 din = 4'd2; load_n = 1'b0; en_par = 1'b1;
    #1 check("R9 no change before edge", qa, 9);
    load_n = 1'b1; en_par = 1'b0;
    tick();
    check("R9 value after edge", qa, 9);
  endtask

  task automatic t_clears();
    #1 clr_a_n = 1'b0; clr_s_n = 1'b0; load_n = 1'b0; din = 4'd6; en_par = 1'b1; en_trk = 1'b1;
    #1 check("R3 async clear mid-cycle", qa, 0);
    check("R2 sync waits for edge", qs, 9);
    tick();
    check("R2 sync clear beats load", qs, 0);
    load_n = 1'b1; tick();
    check("R2 sync clear beats count", qs, 0);
    clr_a_n = 1'b1; clr_s_n = 1'b1; tick();
    check("R5 count after clear", qs, 1);
  endtask

  task automatic t_chain();
    int errs = 0;
    tick(); c_clr_n = 1'b1; c_en = 1'b1;
    for (int i = 1; i <= 4095; i++) begin
      tick();
      if (chain_val != 12'(i)) errs++;
    end
    check("R8 chain sequence", errs, 0);
    check("R8 chain at 4095", chain_val, 4095);
    check("R8 top tc at 4095", ctc[2], 1);
    tick();
    check("R8 chain wrap", chain_val, 0);
    c_en = 1'b0; tick();
    check("R8 chain hold", chain_val, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_count_hold();
    t_load_wrap();
    t_midcycle();
    t_clears();
    t_chain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule